// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Controller

This block controls one dual-role input pin of a clock generator. Right after power-on the pin is a power-good input, active high. The first time the synchronised pin is seen high, the block captures the CPU frequency strap once. It then starts the PLL and releases the clock outputs after the PLL reports lock.

After that first high level, the same pin works as an asynchronous power-down request, active low. The request passes through a synchroniser. It must be seen low on two consecutive rising edges of the reference CPU clock before shutdown begins. On shutdown the differential outputs are forced low at once. Each single-ended output is held low from its next low phase. Only when every output is held does the PLL/oscillator enable drop. At that point the block can also request that the configuration registers return to their defaults.

Releasing the request starts the PLL again. The outputs come back a fixed number of clock cycles after lock is reported.

Top module: `pgpd_ctrl`

## Requirements
- R1: While reset is asserted and right after it: `fs_latched`=0, `diff_low`=1, every bit of `se_hold`=1, `pll_en`=0 and `reg_clear`=0.
- R2: `fs_latched` takes the value of `strap_fs` on the first clock edge at which the synchronised pin is high. Encoding: 0 selects the 133 MHz CPU setting and 1 selects 100 MHz. With test mode off, later changes of the strap or of the pin never change it.
- R3: With `test_mode_en`=1, every new low-to-high transition of the synchronised pin after power-good loads `strap_fs` into `fs_latched` again.
- R4: `pll_en` rises on the third rising edge after the pin goes high, counting the two synchroniser stages. Until the PLL reports lock, `diff_low` stays 1 and `se_hold` stays all ones.
- R5: When the pin falls before rising edge e0, `diff_low` rises after edge e3. A low level that stays for only one clock period never starts shutdown.
- R6: During shutdown, `se_hold[i]` sets only on an edge at which `se_lvl[i]` is 0. Once set, it stays set until the outputs run again.
- R7: `pll_en` falls only while `diff_low`=1 and every `se_hold` bit is 1. It falls one edge after the last hold bit sets.
- R8: When `cfg_keep`=0, `reg_clear` is a single-cycle pulse in the cycle `pll_en` falls. When `cfg_keep`=1 it stays 0.
- R9: On release, `pll_en` rises on the third rising edge after the pin goes high. `diff_low` and `se_hold` clear on the WAKE_CYC-th edge that sees `pll_locked`=1. A loss of lock during that count restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference CPU clock, the only clock of the block |
| rst_n | input | 1 | Power-on reset, active low |
| pg_pd_n | input | 1 | Dual-role pin: power-good at start-up, power-down request (active low) afterwards |
| strap_fs | input | 1 | CPU frequency strap (0 = 133 MHz, 1 = 100 MHz) |
| test_mode_en | input | 1 | Test-mode register bit; allows the strap to be sampled again |
| cfg_keep | input | 1 | Policy register bit: 1 keeps the configuration, 0 clears it at power-down |
| pll_locked | input | 1 | PLL lock indication |
| se_lvl | input | N_SE | Current level of each single-ended output |
| fs_latched | output | 1 | Latched frequency strap |
| se_hold | output | N_SE | Per single-ended output: hold low |
| diff_low | output | 1 | Force all differential outputs low |
| pll_en | output | 1 | PLL and oscillator enable |
| reg_clear | output | 1 | One-cycle request to reset the configuration registers |

## Verification
The hardest state to reach is a partly drained shutdown. Here the differential outputs are already forced low, but one single-ended output is still in its high phase, so the PLL enable must stay up for as long as that phase lasts. The bench gets there by keeping one bit of `se_lvl` high across the power-down entry. It then watches `se_hold` and `pll_en` for several cycles before letting that output fall. The bench also places the request pulse relative to the clock edges so that the synchronised level is low on exactly one sampling edge. This separates a rejected glitch from a qualified request.

// File: rtl/pgpd_pkg.sv
package pgpd_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PG = 3'd0,
    ST_WAKE    = 3'd1,
    ST_RUN     = 3'd2,
    ST_DRAIN   = 3'd3,
    ST_OFF     = 3'd4
  } pgpd_state_e;

  // True when a count that has already reached 'cnt' completes 'lim' events on this edge.
  function automatic logic count_done(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // CPU frequency in MHz for a strap value (0 = 133, 1 = 100).
  function automatic logic [7:0] fs_cpu_mhz(input logic fs);
    return fs ? 8'd100 : 8'd133;
  endfunction

endpackage

// File: rtl/pgpd_sync.sv
module pgpd_sync #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge ref_clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge ref_clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) q_prev <= 1'b0;
    else        q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgpd_low_qual.sv
module pgpd_low_qual #(
  parameter int EDGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic arm,
  input  logic lvl,
  output logic hit
);
  import pgpd_pkg::*;
  localparam int CW = $clog2(EDGES + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                              low_cnt <= '0;
    else if (!arm || lvl)                    low_cnt <= '0;
    else if (32'(low_cnt) < EDGES)           low_cnt <= low_cnt + 1'b1;
  end

  assign hit = arm && !lvl && count_done(32'(low_cnt), EDGES);
endmodule

// File: rtl/pgpd_se_hold.sv
module pgpd_se_hold #(
  parameter int N_SE = 4
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            release_all,
  input  logic [N_SE-1:0] se_lvl,
  output logic [N_SE-1:0] hold
);
  generate
    for (genvar i = 0; i < N_SE; i++) begin : g_out
      always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)           hold[i] <= 1'b1;
        else if (release_all) hold[i] <= 1'b0;
        else if (!se_lvl[i])  hold[i] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pgpd_ctrl.sv
module pgpd_ctrl #(
  parameter int N_SE        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2,
  parameter int WAKE_CYC    = 4
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            pg_pd_n,
  input  logic            strap_fs,
  input  logic            test_mode_en,
  input  logic            cfg_keep,
  input  logic            pll_locked,
  input  logic [N_SE-1:0] se_lvl,
  output logic            fs_latched,
  output logic [N_SE-1:0] se_hold,
  output logic            diff_low,
  output logic            pll_en,
  output logic            reg_clear
);
  import pgpd_pkg::*;
  localparam int WCW = $clog2(WAKE_CYC + 1);

  pgpd_state_e    st_q, st_d;
  logic           pin_s, pin_prev, pin_rise;
  logic           qual_hit, all_held, wake_finish, pg_seen;
  logic [WCW-1:0] wk_cnt;

  pgpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk(ref_clk), .rst_n(rst_n), .d(pg_pd_n), .q(pin_s), .q_prev(pin_prev)
  );

  pgpd_low_qual #(.EDGES(QUAL_EDGES)) u_qual (
    .ref_clk(ref_clk), .rst_n(rst_n), .arm(st_q == ST_RUN), .lvl(pin_s), .hit(qual_hit)
  );

  pgpd_se_hold #(.N_SE(N_SE)) u_hold (
    .ref_clk(ref_clk), .rst_n(rst_n),
    .release_all((st_q == ST_RUN) || wake_finish),
    .se_lvl(se_lvl), .hold(se_hold)
  );

  assign pin_rise    = pin_s && !pin_prev;
  assign all_held    = &se_hold;
  assign wake_finish = (st_q == ST_WAKE) && pll_locked && count_done(32'(wk_cnt), WAKE_CYC);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_WAIT_PG: if (pin_s)       st_d = ST_WAKE;
      ST_WAKE:    if (wake_finish) st_d = ST_RUN;
      ST_RUN:     if (qual_hit)    st_d = ST_DRAIN;
      ST_DRAIN:   if (all_held)    st_d = ST_OFF;
      ST_OFF:     if (pin_s)       st_d = ST_WAKE;
      default:                     st_d = ST_WAIT_PG;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_WAIT_PG;
      wk_cnt     <= '0;
      pg_seen    <= 1'b0;
      fs_latched <= 1'b0;
      reg_clear  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q != ST_WAKE || !pll_locked || wake_finish) wk_cnt <= '0;
      else                                              wk_cnt <= wk_cnt + 1'b1;
      if (st_q == ST_WAIT_PG && pin_s) begin
        pg_seen    <= 1'b1;
        fs_latched <= strap_fs;
      end else if (pg_seen && test_mode_en && pin_rise) begin
        fs_latched <= strap_fs;
      end
      reg_clear <= (st_q == ST_DRAIN) && all_held && !cfg_keep;
    end
  end

  assign diff_low = (st_q != ST_RUN);
  assign pll_en   = (st_q == ST_WAKE) || (st_q == ST_RUN) || (st_q == ST_DRAIN);
endmodule

// File: rtl/pgpd_ctrl_chk.sv
module pgpd_ctrl_chk #(
  parameter int N_SE = 4
) (
  input logic                  ref_clk,
  input logic                  rst_n,
  input logic                  test_mode_en,
  input logic                  cfg_keep,
  input logic                  pll_locked,
  input logic [N_SE-1:0]       se_lvl,
  input logic                  fs_latched,
  input logic [N_SE-1:0]       se_hold,
  input logic                  diff_low,
  input logic                  pll_en,
  input logic                  reg_clear,
  input logic                  pin_s,
  input logic                  pg_seen,
  input pgpd_pkg::pgpd_state_e st_q
);
  import pgpd_pkg::*;

  p_fs_frozen_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pg_seen && $past(pg_seen) && !test_mode_en && !$past(test_mode_en)) |-> $stable(fs_latched));

  p_pll_start_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(pin_s));

  p_entry_two_low_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && $past(st_q) == ST_RUN) |-> (!$past(pin_s) && !$past(pin_s, 2)));

  p_hold_sticky_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st_q != ST_RUN && $past(st_q) != ST_RUN) |-> ((se_hold & $past(se_hold)) == $past(se_hold)));

  generate
    for (genvar i = 0; i < N_SE; i++) begin : g_se
      p_hold_on_low_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(se_hold[i]) |-> !$past(se_lvl[i]));
    end
  endgenerate

  p_pll_off_safe_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pll_en |-> (diff_low && (&se_hold)));

  p_clear_single_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    reg_clear |=> !reg_clear);

  p_clear_policy_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    reg_clear |-> (!pll_en && !$past(cfg_keep)));

  p_run_after_lock_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(diff_low) |-> $past(pll_locked));

endmodule

bind pgpd_ctrl pgpd_ctrl_chk #(.N_SE(N_SE)) u_chk (.*);

// File: tb/pgpd_ctrl_tb.sv
module pgpd_ctrl_tb;
  localparam int N_SE = 4;
  localparam int WAKE_CYC = 4;

  logic            ref_clk = 1'b0;
  logic            rst_n, pg_pd_n, strap_fs, test_mode_en, cfg_keep, pll_locked;
  logic [N_SE-1:0] se_lvl;
  logic            fs_latched, diff_low, pll_en, reg_clear;
  logic [N_SE-1:0] se_hold;
  int              checks = 0;
  int              errors = 0;
  bit              done = 0;

  always #5 ref_clk = ~ref_clk;

  pgpd_ctrl #(.N_SE(N_SE), .WAKE_CYC(WAKE_CYC)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .pg_pd_n(pg_pd_n), .strap_fs(strap_fs),
    .test_mode_en(test_mode_en), .cfg_keep(cfg_keep), .pll_locked(pll_locked),
    .se_lvl(se_lvl), .fs_latched(fs_latched), .se_hold(se_hold),
    .diff_low(diff_low), .pll_en(pll_en), .reg_clear(reg_clear)
  );

  task automatic step(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; pg_pd_n = 0; strap_fs = 1; test_mode_en = 0; cfg_keep = 1;
    pll_locked = 0; se_lvl = '0;
    step(3);
    chk("R1 fs", {7'b0, fs_latched}, 8'h0);
    chk("R1 diff_low", {7'b0, diff_low}, 8'h1);
    chk("R1 se_hold", {4'b0, se_hold}, 8'h0f);
    chk("R1 pll_en/clear", {6'b0, pll_en, reg_clear}, 8'h0);
    rst_n = 1;
    step(4);
    chk("R1 after reset pll_en", {7'b0, pll_en}, 8'h0);
  endtask

  task automatic t_powergood();
    strap_fs = 1; pg_pd_n = 1;
    step(2);
    chk("R4 pll_en before sync", {7'b0, pll_en}, 8'h0);
    step(1);
    chk("R4 pll_en up", {7'b0, pll_en}, 8'h1);
    chk("R2 fs latched 100MHz", {7'b0, fs_latched}, 8'h1);
    strap_fs = 0;
    step(10);
    chk("R2 strap change ignored", {7'b0, fs_latched}, 8'h1);
    chk("R4 held without lock", {3'b0, diff_low, se_hold}, 8'h1f);
    pll_locked = 1;
    step(WAKE_CYC - 1);
    chk("R9 still held", {7'b0, diff_low}, 8'h1);
    step(1);
    chk("R9 running", {3'b0, diff_low, se_hold}, 8'h00);
  endtask

  task automatic t_glitch();
    pg_pd_n = 0;
    step(1);
    pg_pd_n = 1;
    step(8);
    chk("R5 one-edge low ignored", {6'b0, diff_low, pll_en}, 8'h01);
  endtask

  task automatic t_cycle(input logic keep, input logic tm, input logic new_strap, input logic exp_fs);
    cfg_keep = keep; test_mode_en = tm;
    se_lvl = 4'b0010;
    pg_pd_n = 0;
    step(3);
    chk("R5 not yet", {7'b0, diff_low}, 8'h0);
    step(1);
    chk("R5 diff low", {6'b0, diff_low, pll_en}, 8'h3);
    step(1);
    chk("R6 partial hold", {4'b0, se_hold}, 8'h0d);
    step(3);
    chk("R6 high output not held", {4'b0, se_hold}, 8'h0d);
    chk("R7 pll stays on", {7'b0, pll_en}, 8'h1);
    se_lvl = '0;
    step(1);
    chk("R6 all held", {4'b0, se_hold}, 8'h0f);
    chk("R7 pll on one more", {6'b0, pll_en, reg_clear}, 8'h2);
    step(1);
    chk("R7 pll off", {7'b0, pll_en}, 8'h0);
    chk("R8 clear pulse", {7'b0, reg_clear}, {7'b0, !keep});
    step(1);
    chk("R8 clear single", {7'b0, reg_clear}, 8'h0);
    strap_fs = new_strap;
    pg_pd_n = 1;
    step(2);
    chk("R9 pll still off", {7'b0, pll_en}, 8'h0);
    step(1);
    chk("R9 pll restart", {7'b0, pll_en}, 8'h1);
    chk(tm ? "R3 resampled" : "R2 release ignored", {7'b0, fs_latched}, {7'b0, exp_fs});
    step(WAKE_CYC - 1);
    chk("R9 held before count", {7'b0, diff_low}, 8'h1);
    step(1);
    chk("R9 resumed", {3'b0, diff_low, se_hold}, 8'h00);
    test_mode_en = 0;
  endtask

  initial begin
    t_reset();
    t_powergood();
    t_glitch();
    t_cycle(1'b1, 1'b0, 1'b0, 1'b1);
    t_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    t_cycle(1'b1, 1'b1, 1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1-timeout actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule